// File: doc/BRIEF.md
# SPI Timing Parameter Calculator

This block turns a set of timing requirements for one SPI peripheral into the values an SPI master needs. Its inputs are the frequency of the master's root clock, the fastest serial clock the peripheral accepts, and three delays in nanoseconds. The delays are chip-select setup (select asserted to first clock edge), the gap between back-to-back frames, and chip-select hold (last clock edge to select released). It returns a prescale exponent and a packed 32-bit control word. The word holds the serial clock divider and the three delays, each counted in prescaled clock cycles.

The calculation is pure integer arithmetic. It first finds the base clock period. It then converts the longest delay and the clock ratio into root-clock cycles. It picks the smallest power-of-two prescale for which every count fits in 8 bits. Finally it rounds each delay up to whole prescaled periods and removes the fixed cycles the master adds by itself. All divisions share one iterative restoring divider, so a full calculation takes a few hundred cycles.

Software or a sequencer pulses `start` with the inputs valid. `busy` is high while the calculation runs. `done` pulses for one cycle when the results are ready, and the results then hold until the next calculation finishes.

Top module: `spi_timing_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, and `ctrl_word` and `prescale_exp` are 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle. The inputs are captured at that pulse, so later changes to the inputs, and `start` pulses while busy, do not alter the result.
- R3: Let `big` be the larger of the clock ratio (`root_hz / sck_max_hz`) and the longest delay divided by the base period (`1e9 / root_hz`, integer division). `prescale_exp` is 0 if `big` is below 256. Otherwise it is the number of significant bits of `big` minus 8.
- R4: `ctrl_word[7:0]` holds `(ratio >> prescale_exp) - 1`. It holds 0 when the shifted ratio is 0.
- R5: The prescaled period is `1e9 / (root_hz >> prescale_exp)`. `ctrl_word[23:16]` holds the setup delay rounded up to whole prescaled periods, minus 1. A count of 0 is kept as 0.
- R6: `ctrl_word[15:8]` holds the frame gap rounded up to whole prescaled periods, minus 2. A count below 2 is kept unchanged.
- R7: `ctrl_word[31:24]` holds the hold delay rounded up to whole prescaled periods, minus 1. A count of 0 is kept as 0.
- R8: A zero `root_hz`, a zero `sck_max_hz`, or a `root_hz` above 1e9 (which gives a zero base period) ends the calculation with `err` = 1, `ctrl_word` = 0 and `prescale_exp` = 0. A successful calculation clears `err`.
- R9: `done` is high for exactly one cycle per accepted `start`. `busy` is low in that cycle and after it. The outputs change only in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation; inputs sampled in this cycle |
| root_hz | input | 32 | Root clock frequency in Hz |
| sck_max_hz | input | 32 | Highest permitted serial clock in Hz |
| setup_ns | input | 32 | Select-to-first-edge delay in ns |
| gap_ns | input | 32 | Gap between frames in ns |
| hold_ns | input | 32 | Last-edge-to-deselect delay in ns |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | Last calculation hit a zero divisor |
| prescale_exp | output | 5 | Power-of-two prescale exponent |
| ctrl_word | output | 32 | Packed divider, gap, setup and hold fields |

## Verification
The bench sweeps a grid of root clocks, from kilohertz up to exactly 1 GHz, against serial clock limits and four delay sets. The delay sets range from all-zero through tens of nanoseconds and hundreds of microseconds to a delay near the 32-bit limit. Low-root cases drive the clock ratio to zero and test the divider clamp. Small delays separate the offset clamps from the subtractions. The large delay forces the highest prescale exponents, which tells apart the prescale rule and the rounding to prescaled periods. Separate runs feed each zero-divisor condition, change the inputs and pulse `start` while busy, and confirm the error flag clears on the next valid calculation.

// File: rtl/spi_tc_pkg.sv
package spi_tc_pkg;

    localparam int DW = 32;                       // arithmetic width
    localparam int FW = 8;                        // width of each packed field
    localparam int EW = $clog2(DW - FW + 1);      // prescale exponent width
    localparam int CW = $clog2(DW + 1);           // divider step counter width
    localparam logic [DW-1:0] NS_PER_S = DW'(1_000_000_000);
    localparam logic [1:0] GAP_OFFSET  = 2'd2;
    localparam logic [1:0] EDGE_OFFSET = 2'd1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BASE,    // 1e9 / root
        ST_RATIO,   // root / sck limit
        ST_CYC,     // longest delay / base period
        ST_EXP,     // latch exponent
        ST_PER,     // 1e9 / (root >> exp)
        ST_SETUP,
        ST_GAP,
        ST_HOLD,
        ST_PACK,
        ST_FAIL
    } calc_state_t;

    typedef struct packed {
        logic [FW-1:0] hold;
        logic [FW-1:0] setup;
        logic [FW-1:0] gap;
        logic [FW-1:0] sck;
    } ctrl_word_t;

    function automatic logic [DW-1:0] umax(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_tc_divider.sv
module spi_tc_divider #(
    parameter int W  = spi_tc_pkg::DW,
    parameter int CW = spi_tc_pkg::CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] steps;
    logic          running;
    logic [W:0]    trial;
    logic [W:0]    shifted;

    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo     <= '0;
            rem     <= '0;
            dvs_q   <= '0;
            steps   <= '0;
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                quo     <= dividend;
                rem     <= '0;
                dvs_q   <= divisor;
                steps   <= CW'(W);
                running <= 1'b1;
            end else if (running) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= shifted[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                steps <= steps - 1'b1;
                if (steps == CW'(1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_tc_prescale.sv
module spi_tc_prescale #(
    parameter int W  = spi_tc_pkg::DW,
    parameter int FW = spi_tc_pkg::FW,
    parameter int EW = spi_tc_pkg::EW
) (
    input  logic [W-1:0]  cycles,
    input  logic [W-1:0]  ratio,
    output logic [EW-1:0] expo
);
    logic [W-1:0] big;
    int unsigned  bits;

    always_comb begin
        big  = (cycles > ratio) ? cycles : ratio;
        bits = 0;
        for (int i = 0; i < W; i++) begin
            if (big[i]) bits = i + 1;
        end
        expo = (bits > FW) ? EW'(bits - FW) : '0;
    end
endmodule

// File: rtl/spi_tc_field.sv
module spi_tc_field #(
    parameter int W  = spi_tc_pkg::DW,
    parameter int FW = spi_tc_pkg::FW
) (
    input  logic [W-1:0]  quo,
    input  logic          round_up,
    input  logic [1:0]    offset,
    output logic [FW-1:0] field
);
    logic [W:0] count;
    logic [W:0] trimmed;

    always_comb begin
        count   = {1'b0, quo} + {{W{1'b0}}, round_up};
        trimmed = (count >= {{(W-1){1'b0}}, offset}) ? count - {{(W-1){1'b0}}, offset} : count;
        field   = (trimmed > {{(W+1-FW){1'b0}}, {FW{1'b1}}}) ? {FW{1'b1}} : trimmed[FW-1:0];
    end
endmodule

// File: rtl/spi_timing_calc.sv
module spi_timing_calc
    import spi_tc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] root_hz,
    input  logic [DW-1:0] sck_max_hz,
    input  logic [DW-1:0] setup_ns,
    input  logic [DW-1:0] gap_ns,
    input  logic [DW-1:0] hold_ns,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [EW-1:0] prescale_exp,
    output logic [DW-1:0] ctrl_word
);
    calc_state_t   st;
    logic          launched;
    logic [DW-1:0] l_root, l_sck, l_setup, l_gap, l_hold, l_maxd;
    logic [DW-1:0] base_per, ratio, cyc_req, per;
    logic [EW-1:0] exp_q, exp_next;
    ctrl_word_t    acc;

    logic          in_div, dv_go, dv_zero, dv_fin;
    logic [DW-1:0] dv_a, dv_b, dv_q, dv_r;
    logic [1:0]    off_sel;
    logic [FW-1:0] dly_field, sck_field;

    always_comb begin
        in_div  = 1'b1;
        dv_a    = '0;
        dv_b    = '0;
        off_sel = EDGE_OFFSET;
        unique case (st)
            ST_BASE:  begin dv_a = NS_PER_S; dv_b = l_root;          end
            ST_RATIO: begin dv_a = l_root;   dv_b = l_sck;           end
            ST_CYC:   begin dv_a = l_maxd;   dv_b = base_per;        end
            ST_PER:   begin dv_a = NS_PER_S; dv_b = l_root >> exp_q; end
            ST_SETUP: begin dv_a = l_setup;  dv_b = per;             end
            ST_GAP:   begin dv_a = l_gap;    dv_b = per; off_sel = GAP_OFFSET; end
            ST_HOLD:  begin dv_a = l_hold;   dv_b = per;             end
            default:  in_div = 1'b0;
        endcase
        dv_zero = in_div && !launched && (dv_b == '0);
        dv_go   = in_div && !launched && (dv_b != '0);
    end

    spi_tc_divider #(.W(DW), .CW(CW)) u_div (
        .clk(clk), .rst(rst), .go(dv_go), .dividend(dv_a), .divisor(dv_b),
        .quo(dv_q), .rem(dv_r), .fin(dv_fin)
    );

    spi_tc_prescale #(.W(DW), .FW(FW), .EW(EW)) u_pre (
        .cycles(cyc_req), .ratio(ratio), .expo(exp_next)
    );

    spi_tc_field #(.W(DW), .FW(FW)) u_dly_fmt (
        .quo(dv_q), .round_up(|dv_r), .offset(off_sel), .field(dly_field)
    );

    spi_tc_field #(.W(DW), .FW(FW)) u_sck_fmt (
        .quo(ratio >> exp_q), .round_up(1'b0), .offset(EDGE_OFFSET), .field(sck_field)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            launched     <= 1'b0;
            busy         <= 1'b0;
            done         <= 1'b0;
            err          <= 1'b0;
            prescale_exp <= '0;
            ctrl_word    <= '0;
            l_root       <= '0;
            l_sck        <= '0;
            l_setup      <= '0;
            l_gap        <= '0;
            l_hold       <= '0;
            l_maxd       <= '0;
            base_per     <= '0;
            ratio        <= '0;
            cyc_req      <= '0;
            per          <= '0;
            exp_q        <= '0;
            acc          <= '0;
        end else begin
            done <= 1'b0;
            if (st == ST_IDLE) begin
                if (start) begin
                    l_root   <= root_hz;
                    l_sck    <= sck_max_hz;
                    l_setup  <= setup_ns;
                    l_gap    <= gap_ns;
                    l_hold   <= hold_ns;
                    l_maxd   <= umax(umax(setup_ns, gap_ns), hold_ns);
                    launched <= 1'b0;
                    busy     <= 1'b1;
                    st       <= ST_BASE;
                end
            end else if (in_div) begin
                if (dv_zero) begin
                    st <= ST_FAIL;
                end else if (!launched) begin
                    launched <= 1'b1;
                end else if (dv_fin) begin
                    launched <= 1'b0;
                    unique case (st)
                        ST_BASE:  begin base_per  <= dv_q;      st <= ST_RATIO; end
                        ST_RATIO: begin ratio     <= dv_q;      st <= ST_CYC;   end
                        ST_CYC:   begin cyc_req   <= dv_q;      st <= ST_EXP;   end
                        ST_PER:   begin per       <= dv_q;      st <= ST_SETUP; end
                        ST_SETUP: begin acc.setup <= dly_field; st <= ST_GAP;   end
                        ST_GAP:   begin acc.gap   <= dly_field; st <= ST_HOLD;  end
                        default:  begin acc.hold  <= dly_field; st <= ST_PACK;  end
                    endcase
                end
            end else if (st == ST_EXP) begin
                exp_q <= exp_next;
                st    <= ST_PER;
            end else if (st == ST_PACK) begin
                ctrl_word    <= {acc.hold, acc.setup, acc.gap, sck_field};
                prescale_exp <= exp_q;
                err          <= 1'b0;
                done         <= 1'b1;
                busy         <= 1'b0;
                st           <= ST_IDLE;
            end else begin
                ctrl_word    <= '0;
                prescale_exp <= '0;
                err          <= 1'b1;
                done         <= 1'b1;
                busy         <= 1'b0;
                st           <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/spi_timing_calc_chk.sv
module spi_timing_calc_chk
    import spi_tc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [EW-1:0] prescale_exp,
    input logic [DW-1:0] ctrl_word
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ctrl_word) && $stable(prescale_exp) && $stable(err)));

    a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r8_err_clears_word: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (ctrl_word == '0 && prescale_exp == '0));

    a_r3_exp_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (prescale_exp <= EW'(DW - FW)));
endmodule

bind spi_timing_calc spi_timing_calc_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err(err), .prescale_exp(prescale_exp), .ctrl_word(ctrl_word)
);

// File: tb/spi_timing_calc_test.sv
module spi_timing_calc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] root_hz = '0, sck_max_hz = '0, setup_ns = '0, gap_ns = '0, hold_ns = '0;
    logic        busy, done, err;
    logic [4:0]  prescale_exp;
    logic [31:0] ctrl_word;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_timing_calc uut (
        .clk(clk), .rst(rst), .start(start), .root_hz(root_hz), .sck_max_hz(sck_max_hz),
        .setup_ns(setup_ns), .gap_ns(gap_ns), .hold_ns(hold_ns),
        .busy(busy), .done(done), .err(err), .prescale_exp(prescale_exp), .ctrl_word(ctrl_word)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint sub_clamp(input longint c, input longint off);
        longint t;
        t = (c >= off) ? c - off : c;
        return (t > 255) ? 255 : t;
    endfunction

    function automatic void model(input longint r, input longint m, input longint s,
                                  input longint g, input longint h,
                                  output bit e, output longint x, output longint w);
        longint base, ratio, mx, cyc, big, sr, per, sck;
        int bits;
        e = 0; x = 0; w = 0;
        if (r == 0 || m == 0 || r > 1000000000) begin
            e = 1;
            return;
        end
        base  = 1000000000 / r;
        ratio = r / m;
        mx    = (s > g) ? s : g;
        mx    = (mx > h) ? mx : h;
        cyc   = mx / base;
        big   = (cyc > ratio) ? cyc : ratio;
        bits  = 0;
        for (int i = 0; i < 40; i++) if (big[i]) bits = i + 1;
        x     = (bits > 8) ? bits - 8 : 0;
        sr    = r >> x;
        per   = 1000000000 / sr;
        sck   = ratio >> x;
        sck   = (sck == 0) ? 0 : ((sck - 1 > 255) ? 255 : sck - 1);
        w = (sub_clamp((h + per - 1) / per, 1) << 24) |
            (sub_clamp((s + per - 1) / per, 1) << 16) |
            (sub_clamp((g + per - 1) / per, 2) << 8)  | sck;
    endfunction

    task automatic wait_done(output bit ok);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ok = done;
    endtask

    task automatic compare(input longint r, input longint m, input longint s,
                           input longint g, input longint h);
        bit e; longint x, w;
        model(r, m, s, g, h, e, x, w);
        chk(err == e, "R8 err", err, e);
        chk(prescale_exp == x, "R3 prescale_exp", prescale_exp, x);
        chk(ctrl_word[7:0] == w[7:0], "R4 divider field", ctrl_word[7:0], w[7:0]);
        chk(ctrl_word[15:8] == w[15:8], "R6 gap field", ctrl_word[15:8], w[15:8]);
        chk(ctrl_word[23:16] == w[23:16], "R5 setup field", ctrl_word[23:16], w[23:16]);
        chk(ctrl_word[31:24] == w[31:24], "R7 hold field", ctrl_word[31:24], w[31:24]);
    endtask

    task automatic run_case(input logic [31:0] r, input logic [31:0] m, input logic [31:0] s,
                            input logic [31:0] g, input logic [31:0] h);
        bit ok;
        @(negedge clk);
        root_hz = r; sck_max_hz = m; setup_ns = s; gap_ns = g; hold_ns = h;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_done(ok);
        chk(ok, "R9 done reached", ok, 1);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        compare(r, m, s, g, h);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] roots [6] = '{32'd1_000_000_000, 32'd200_000_000, 32'd133_000_000,
                                   32'd24_000_000, 32'd1_000_000, 32'd3000};
        logic [31:0] scks  [4] = '{32'd50_000_000, 32'd12_000_000, 32'd166_666, 32'd1000};
        logic [31:0] dset  [4][3] = '{'{32'd0, 32'd0, 32'd0},
                                      '{32'd40, 32'd0, 32'd40},
                                      '{32'd100_000, 32'd52_000, 32'd20_000},
                                      '{32'd5_000_000, 32'd1, 32'd4_000_000_000}};
        bit ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && err == 0, "R1 flags after reset", {busy, done, err}, 0);
        chk(ctrl_word == 0, "R1 word after reset", ctrl_word, 0);
        chk(prescale_exp == 0, "R1 exponent after reset", prescale_exp, 0);

        for (int ri = 0; ri < 6; ri++)
            for (int mi = 0; mi < 4; mi++)
                for (int di = 0; di < 4; di++)
                    run_case(roots[ri], scks[mi], dset[di][0], dset[di][1], dset[di][2]);

        // R8 zero-divisor cases, then recovery
        run_case(32'd0, 32'd1_000_000, 32'd10, 32'd10, 32'd10);
        run_case(32'd100_000_000, 32'd0, 32'd10, 32'd10, 32'd10);
        run_case(32'd1_000_000_001, 32'd1_000_000, 32'd10, 32'd10, 32'd10);
        run_case(32'd100_000_000, 32'd10_000_000, 32'd25, 32'd25, 32'd25);
        chk(err == 0, "R8 err cleared by valid run", err, 0);

        // R2 inputs changed and start pulsed while busy
        @(negedge clk);
        root_hz = 32'd80_000_000; sck_max_hz = 32'd2_000_000;
        setup_ns = 32'd3000; gap_ns = 32'd700; hold_ns = 32'd90;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        root_hz = 32'd0; sck_max_hz = 32'd7; setup_ns = 32'd99_999; gap_ns = 32'd5; hold_ns = 32'd1;
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk(ok, "R2 done after busy start", ok, 1);
        compare(80_000_000, 2_000_000, 3000, 700, 90);
        repeat (400) @(negedge clk);
        chk(done == 0 && busy == 0, "R2 start during busy not queued", {done, busy}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule